// File: doc/BRIEF.md
# Bidirectional Port Register File

This block holds the per-pin state of a general-purpose I/O expander. A narrow internal register bus addresses it. There are four byte-wide registers: pin sample, drive value, input inversion and direction. The block turns their contents into an output-enable and an output level for each tristate pad. It also brings the pad levels through a synchronizer and captures them on request.

A serial front end, outside this block, performs the register accesses. Writes act on the clock edge where the write strobe is high. Read data is a combinational function of the register select. At the point in a read transfer where the pin sample must be frozen, the front end pulses a capture strobe. The block also exports the synchronized pin levels and the captured sample, so that a separate change detector can compare them.

Top module: `gpio_portbank`

## Requirements
- R1: After reset the drive register reads 0xFF, the inversion register 0x00, the direction register 0xFF and the captured sample 0x00. Every pad output-enable and pad output is then 0.
- R2: Register select 0 reads the pin sample, 1 the drive register, 2 the inversion register and 3 the direction register. A value written to select 1, 2 or 3 reads back unchanged from that select only.
- R3: A write to select 0 changes no register, no pad output-enable and no pad output.
- R4: Select 0 reads the captured sample XOR the inversion register, bit by bit. A bit set to 1 in the inversion register inverts that bit; a bit set to 0 passes it unchanged. This holds whatever the direction of each pin.
- R5: A direction bit of 1 makes the pin an input: output-enable is 0 and the pad output is 0. A direction bit of 0 gives output-enable 1, and the pad output equals the drive register bit.
- R6: Select 1 reads the stored drive value, not the pad level, including for bits whose pin is an input.
- R7: A value written to the drive or direction register appears on the pads in the cycle after the write strobe, and not before.
- R8: The synchronized pin level output follows a pad input change after two clock edges, not one.
- R9: The captured sample loads the synchronized pin levels only on a clock edge where the capture strobe is high, and holds otherwise.
- R10: Asserting reset in the middle of operation restores every R1 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| snap_i | input | 1 | Capture strobe for the pin sample |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output-enable |
| pad_out | output | 8 | Per-pin output level |
| pin_level_o | output | 8 | Synchronized pin levels, for the change detector |
| pin_held_o | output | 8 | Captured pin sample, without inversion |

## Verification
The bench builds the block with its defaults: eight pins, a two-stage synchronizer and capture mode on. At that size all 256 pad input patterns can be swept under four inversion masks and four direction settings. All 256 direction values can also be swept against changing drive values. This covers every bit of the inversion XOR and every combination of output-enable and drive, including inputs with a stored drive value of 1. The two-stage depth makes the one-edge/two-edge boundary of the synchronizer observable at the ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned BANK_SEL_W = 2;

   typedef enum logic [BANK_SEL_W-1:0] {
      SEL_PIN_IN = 2'd0,
      SEL_DRIVE  = 2'd1,
      SEL_INVERT = 2'd2,
      SEL_DIR    = 2'd3
   } bank_sel_e;

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
   parameter logic DRIVE_RST  = 1'b1,
   parameter logic INVERT_RST = 1'b0,
   parameter logic DIR_RST    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_drive,
   input  logic wr_invert,
   input  logic wr_dir,
   input  logic wbit,
   output logic drive_q,
   output logic invert_q,
   output logic dir_q,
   output logic pad_oe,
   output logic pad_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q  <= DRIVE_RST;
         invert_q <= INVERT_RST;
         dir_q    <= DIR_RST;
      end else begin
         if (wr_drive)  drive_q  <= wbit;
         if (wr_invert) invert_q <= wbit;
         if (wr_dir)    dir_q    <= wbit;
      end
   end

   // direction 1 = input: driver released, level forced low
   assign pad_oe  = ~dir_q;
   assign pad_out = drive_q & ~dir_q;

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_bank_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [BANK_SEL_W-1:0] sel,
   input  logic [W-1:0]          sample,
   input  logic [W-1:0]          invert,
   input  logic [W-1:0]          drive,
   input  logic [W-1:0]          dir,
   output logic [W-1:0]          rdata
);

   always_comb begin
      unique case (bank_sel_e'(sel))
         SEL_PIN_IN: rdata = sample ^ invert;
         SEL_DRIVE:  rdata = drive;
         SEL_INVERT: rdata = invert;
         SEL_DIR:    rdata = dir;
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_portbank.sv
module gpio_portbank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SNAPSHOT_EN = 1'b1,
   parameter logic [PIN_W-1:0] DRIVE_RESET  = '1,
   parameter logic [PIN_W-1:0] INVERT_RESET = '0,
   parameter logic [PIN_W-1:0] DIR_RESET    = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [BANK_SEL_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic [PIN_W-1:0]      bus_wdata,
   output logic [PIN_W-1:0]      bus_rdata,
   input  logic                  snap_i,
   input  logic [PIN_W-1:0]      pad_in,
   output logic [PIN_W-1:0]      pad_oe,
   output logic [PIN_W-1:0]      pad_out,
   output logic [PIN_W-1:0]      pin_level_o,
   output logic [PIN_W-1:0]      pin_held_o
);

   localparam int unsigned MAX_PINS = 32;

   if (PIN_W < 1 || PIN_W > MAX_PINS) begin : g_bad_width
      $error("gpio_portbank: PIN_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_portbank: SYNC_STAGES must be at least 2");
   end

   // write decode: select 0 decodes to nothing
   logic wr_drive, wr_invert, wr_dir;
   assign wr_drive  = bus_wr && (bank_sel_e'(bus_addr) == SEL_DRIVE);
   assign wr_invert = bus_wr && (bank_sel_e'(bus_addr) == SEL_INVERT);
   assign wr_dir    = bus_wr && (bank_sel_e'(bus_addr) == SEL_DIR);

   logic [PIN_W-1:0] drive_q, invert_q, dir_q;

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      gpio_pin_cell #(
         .DRIVE_RST  (DRIVE_RESET[i]),
         .INVERT_RST (INVERT_RESET[i]),
         .DIR_RST    (DIR_RESET[i])
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_drive  (wr_drive),
         .wr_invert (wr_invert),
         .wr_dir    (wr_dir),
         .wbit      (bus_wdata[i]),
         .drive_q   (drive_q[i]),
         .invert_q  (invert_q[i]),
         .dir_q     (dir_q[i]),
         .pad_oe    (pad_oe[i]),
         .pad_out   (pad_out[i])
      );
   end

   gpio_sync_chain #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_level_o)
   );

   if (SNAPSHOT_EN) begin : g_snap
      logic [PIN_W-1:0] held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      held_q <= '0;
         else if (snap_i) held_q <= pin_level_o;
      end
      assign pin_held_o = held_q;
   end else begin : g_live
      logic unused_snap;
      assign unused_snap = snap_i;
      assign pin_held_o  = pin_level_o;
   end

   gpio_read_mux #(
      .W (PIN_W)
   ) u_rmux (
      .sel    (bus_addr),
      .sample (pin_held_o),
      .invert (invert_q),
      .drive  (drive_q),
      .dir    (dir_q),
      .rdata  (bus_rdata)
   );

endmodule

// File: rtl/gpio_portbank_chk.sv
module gpio_portbank_chk #(
   parameter int unsigned PIN_W       = 8,
   parameter bit          SNAPSHOT_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_wr,
   input logic [PIN_W-1:0] bus_wdata,
   input logic             snap_i,
   input logic [PIN_W-1:0] pad_oe,
   input logic [PIN_W-1:0] pad_out,
   input logic [PIN_W-1:0] pin_level_o,
   input logic [PIN_W-1:0] pin_held_o
);

   // R5
   released_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R7
   dir_write_reaches_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> pad_oe == ~$past(bus_wdata));

   // R7
   drive_write_reaches_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1) |=> (pad_out & pad_oe) == ($past(bus_wdata) & pad_oe));

   // R3
   sample_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> ($stable(pad_oe) && $stable(pad_out)));

   if (SNAPSHOT_EN) begin : g_snap_chk
      // R9
      snap_loads_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         snap_i |=> pin_held_o == $past(pin_level_o));
      // R9
      held_without_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !snap_i |=> $stable(pin_held_o));
   end

endmodule

bind gpio_portbank gpio_portbank_chk #(
   .PIN_W       (PIN_W),
   .SNAPSHOT_EN (SNAPSHOT_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .snap_i      (snap_i),
   .pad_oe      (pad_oe),
   .pad_out     (pad_out),
   .pin_level_o (pin_level_o),
   .pin_held_o  (pin_held_o)
);

// File: tb/tb_gpio_portbank.sv
module tb_gpio_portbank;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         snap_i = 1'b0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_oe, pad_out, pin_level_o, pin_held_o;

   int vectors = 0;
   int fails = 0;

   logic [W-1:0] e_drive, e_inv, e_dir, e_held;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_portbank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snap_i(snap_i),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pin_level_o(pin_level_o), .pin_held_o(pin_held_o)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic check_regs(input string tag);
      logic [W-1:0] r;
      rd(2'd0, r); chk({tag, " sel0"}, r, e_held ^ e_inv);
      rd(2'd1, r); chk({tag, " sel1"}, r, e_drive);
      rd(2'd2, r); chk({tag, " sel2"}, r, e_inv);
      rd(2'd3, r); chk({tag, " sel3"}, r, e_dir);
      chk({tag, " oe"},  pad_oe,  ~e_dir);
      chk({tag, " out"}, pad_out, e_drive & ~e_dir);
   endtask

   task automatic set_defaults();
      e_drive = 8'hFF; e_inv = 8'h00; e_dir = 8'hFF; e_held = 8'h00;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] r;
      logic [W-1:0] inv_set [4];
      logic [W-1:0] dir_set [4];
      inv_set = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
      dir_set = '{8'hFF, 8'h00, 8'h0F, 8'hF0};

      // R1 reset state
      set_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs("R1 reset");
      chk("R1 held", pin_held_o, 8'h00);

      // R2 distinct register map
      wr(2'd1, 8'h12); e_drive = 8'h12;
      wr(2'd2, 8'h34); e_inv   = 8'h34;
      wr(2'd3, 8'h56); e_dir   = 8'h56;
      check_regs("R2 map");

      // R3 writes to select 0 ignored
      for (int v = 0; v < 256; v += 17) begin
         wr(2'd0, 8'(v));
         check_regs("R3 sel0 write");
      end

      // R4 R8 R9 sweep of pad patterns under inversion masks and directions
      for (int k = 0; k < 4; k++) begin
         wr(2'd2, inv_set[k]); e_inv = inv_set[k];
         wr(2'd3, dir_set[k]); e_dir = dir_set[k];
         for (int v = 0; v < 256; v++) begin
            logic [W-1:0] prev;
            prev   = pin_level_o;
            pad_in = 8'(v);
            @(negedge clk);
            chk("R8 one edge", pin_level_o, prev);
            @(negedge clk);
            chk("R8 two edges", pin_level_o, 8'(v));
            chk("R9 no capture", pin_held_o, e_held);
            snap_i = 1'b1;
            @(negedge clk);
            snap_i = 1'b0;
            e_held = 8'(v);
            chk("R9 captured", pin_held_o, e_held);
            rd(2'd0, r);
            chk("R4 inverted sample", r, 8'(v) ^ e_inv);
         end
      end

      // R5 R6 R7 sweep of directions with changing drive values
      wr(2'd2, 8'h00); e_inv = 8'h00;
      for (int d = 0; d < 256; d++) begin
         logic [W-1:0] o;
         o = 8'(d) ^ 8'h5A;
         bus_addr = 2'd3; bus_wdata = 8'(d); bus_wr = 1'b1;
         #1;
         chk("R7 oe before edge", pad_oe, ~e_dir);
         @(negedge clk);
         bus_wr = 1'b0; e_dir = 8'(d);
         chk("R5 oe", pad_oe, ~e_dir);
         bus_addr = 2'd1; bus_wdata = o; bus_wr = 1'b1;
         #1;
         chk("R7 out before edge", pad_out, e_drive & ~e_dir);
         @(negedge clk);
         bus_wr = 1'b0; e_drive = o;
         chk("R5 out", pad_out, o & ~e_dir);
         rd(2'd1, r);
         chk("R6 drive readback", r, o);
      end

      // R10 reset mid-operation
      wr(2'd3, 8'h00); e_dir = 8'h00;
      pad_in = 8'hC3;
      repeat (2) @(negedge clk);
      snap_i = 1'b1; @(negedge clk); snap_i = 1'b0; e_held = 8'hC3;
      check_regs("R10 before reset");
      rst_n = 1'b0;
      @(negedge clk);
      set_defaults();
      check_regs("R10 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_regs("R10 after reset");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule